// File: doc/BRIEF.md
# Prioritized Interrupt Level Controller for Two Processors

The block collects five interrupt sources and gives each processor a 4-bit request level. Four of the sources are shared by both processors and are latched only once: a reset-button event, vertical blank, horizontal blank and a PWM timer event. The fifth is a command interrupt, and each processor has its own latch for it. A host write sets a command latch. Software acknowledges a source by writing to the clear word for that source. Each processor also has its own 4-bit enable mask. The reset source is always enabled, whatever the mask holds.

The level a processor sees is an even number: 14 for reset, 12 for vertical blank, 10 for horizontal blank, 8 for command and 6 for PWM. It is 0 when no enabled source is pending. A processor asks to take an interrupt through a request input and supplies the interrupt mask from its status register. The block accepts the request only when the level is strictly above that mask. On acceptance it returns the exception vector and the new status-register mask.

Top module: `irl_ctrl`

## Requirements
- R1: After reset, all latches and enable masks are zero, both levels are 0 and no acceptance is signalled.
- R2: The level is the highest pending enabled source's level, with reset 14 > vertical blank 12 > horizontal blank 10 > command 8 > PWM 6, or 0 if none.
- R3: Each processor's mask is written by a write to offset 0x00, with data bits [3:0] enabling PWM (bit 0), command (bit 1), horizontal blank (bit 2) and vertical blank (bit 3). A pending reset source gives level 14 even with a zero mask.
- R4: The level outputs are registered. A source pulse, clear write or mask write changes the level output one clock after the latch or mask takes the new value. The level is stable while latches and masks hold.
- R5: A shared source pulse is seen by both processors. A clear of a shared source by either processor removes it for both.
- R6: A host control write with bit 0 = 1 sets that processor's command latch, and a write with bit 0 = 0 has no effect. A write to offset 0x1A clears only the writing processor's command latch.
- R7: A write to offset 0x14 clears reset, 0x16 clears vertical blank, 0x18 clears horizontal blank and 0x1C clears PWM. A write to any other offset, such as 0x12, leaves all latches unchanged.
- R8: When a source is set and cleared in the same cycle, the latch ends up set.
- R9: A request is accepted, with the accept output high one clock later, only when the current level is strictly greater than the supplied status-register mask. Otherwise the accept output stays low.
- R10: On acceptance, the vector output is 64 + level/2 and the new mask output equals the accepted level.
- R11: Acceptance does not clear any latch. A refused or accepted source stays pending until it is cleared, and it is accepted on a later request once the status mask is below its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rst_evt_i | input | 1 | Reset-button event pulse (shared) |
| vblank_i | input | 1 | Vertical blank event pulse (shared) |
| hblank_i | input | 1 | Horizontal blank event pulse (shared) |
| pwm_i | input | 1 | PWM timer event pulse (shared) |
| host_we_i | input | NCPU | Host control write strobe, one per processor |
| host_d0_i | input | NCPU | Bit 0 of the host control byte, one per processor |
| cpu_we_i | input | NCPU | Processor register write strobe |
| cpu_addr_i | input | NCPU*8 | Processor write offset, one byte per processor |
| cpu_wdata_i | input | NCPU*4 | Processor write data nibble (mask value) |
| acc_req_i | input | NCPU | Interrupt take request |
| sr_imask_i | input | NCPU*4 | Status-register interrupt mask, per processor |
| irl_o | output | NCPU*4 | Registered request level, per processor |
| acc_o | output | NCPU | Acceptance pulse |
| vec_o | output | NCPU*8 | Exception vector of the last acceptance |
| new_imask_o | output | NCPU*4 | Status mask to load after the last acceptance |

## Verification
If a latch is lost or duplicated, the level port shows a wrong value two clocks after the stimulus. A shared latch goes wrong on both processors at once, and a command latch goes wrong on only one. A bad enable mask shows up the same way, but only while a non-reset source is pending, so the bench sets masks while several sources are pending. A wrong compare or vector shows up on the accept, vector and new-mask ports in the clock after the request. Equal level and mask is the corner case that separates a strict compare from an inclusive one.

// File: rtl/irl_pkg.sv
package irl_pkg;
  localparam int SRC_N  = 5;
  localparam int LVL_W  = 4;
  localparam int VEC_W  = 8;
  localparam int ADDR_W = 8;
  localparam int VEC_BASE = 64;

  // effective vector bit order: 0 pwm, 1 cmd, 2 hblank, 3 vblank, 4 reset
  localparam int IDX_OFFSET = 3;

  localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CLR_RS = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_CLR_VB = 8'h16;
  localparam logic [ADDR_W-1:0] OFS_CLR_HB = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_CLR_CM = 8'h1A;
  localparam logic [ADDR_W-1:0] OFS_CLR_PW = 8'h1C;

  typedef struct packed {
    logic rs;
    logic vb;
    logic hb;
    logic pw;
  } shared_t;

  typedef struct packed {
    logic rs;
    logic vb;
    logic hb;
    logic cm;
    logic pw;
    logic mask_we;
  } dec_t;

  // highest set bit index, scaled to an even level
  function automatic logic [LVL_W-1:0] irl_level(input logic [SRC_N-1:0] eff);
    logic [LVL_W-1:0] l;
    l = '0;
    for (int i = 0; i < SRC_N; i++)
      if (eff[i]) l = LVL_W'(2 * (i + IDX_OFFSET));
    return l;
  endfunction

  function automatic logic [VEC_W-1:0] irl_vector(input logic [LVL_W-1:0] lvl);
    return VEC_W'(VEC_BASE) + VEC_W'(lvl >> 1);
  endfunction
endpackage

// File: rtl/irl_regif.sv
module irl_regif
  import irl_pkg::*;
(
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output dec_t              dec_o
);
  always_comb begin
    dec_o = '0;
    if (we_i) begin
      unique case (addr_i)
        OFS_MASK:   dec_o.mask_we = 1'b1;
        OFS_CLR_RS: dec_o.rs      = 1'b1;
        OFS_CLR_VB: dec_o.vb      = 1'b1;
        OFS_CLR_HB: dec_o.hb      = 1'b1;
        OFS_CLR_CM: dec_o.cm      = 1'b1;
        OFS_CLR_PW: dec_o.pw      = 1'b1;
        default:    dec_o         = '0;
      endcase
    end
  end
endmodule

// File: rtl/irl_shared_latch.sv
module irl_shared_latch
  import irl_pkg::*;
#(
  parameter int NCPU = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  shared_t set_i,
  input  shared_t clr_i [NCPU],
  output shared_t q_o
);
  shared_t clr_any;
  shared_t q;

  always_comb begin
    clr_any = '0;
    for (int c = 0; c < NCPU; c++) clr_any = clr_any | clr_i[c];
  end

  // a new event in the same cycle as an acknowledge is kept
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr_any) | set_i;
  end

  assign q_o = q;

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i.pw |=> q.pw);
  // R7
  clr_pwm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_any.pw && !set_i.pw) |=> !q.pw);
  // R5
  hold_rs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_any.rs && !set_i.rs) |=> (q.rs == $past(q.rs)));
endmodule

// File: rtl/irl_cpu_core.sv
module irl_cpu_core
  import irl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  shared_t          shared_i,
  input  dec_t             dec_i,
  input  logic [3:0]       mask_d_i,
  input  logic             host_we_i,
  input  logic             host_d0_i,
  output logic [LVL_W-1:0] lvl_o
);
  logic             cmd_q;
  logic [3:0]       mask_q;
  logic [SRC_N-1:0] eff;
  logic [LVL_W-1:0] lvl_q;
  logic             cmd_set;

  assign cmd_set = host_we_i & host_d0_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= 1'b0;
      mask_q <= '0;
    end else begin
      cmd_q <= (cmd_q & ~dec_i.cm) | cmd_set;
      if (dec_i.mask_we) mask_q <= mask_d_i;
    end
  end

  assign eff = {shared_i.rs,
                shared_i.vb & mask_q[3],
                shared_i.hb & mask_q[2],
                cmd_q       & mask_q[1],
                shared_i.pw & mask_q[0]};

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= irl_level(eff);
  end

  assign lvl_o = lvl_q;

  // R4
  lvl_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(eff) |=> $stable(lvl_q));
  // R3
  rst_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shared_i.rs |=> (lvl_q == 4'd14));
  // R2
  lvl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q != 4'd0) |-> (!lvl_q[0] && lvl_q >= 4'd6));
  // R6
  cmd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_set |=> cmd_q);
endmodule

// File: rtl/irl_accept.sv
module irl_accept
  import irl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic             req_i,
  input  logic [LVL_W-1:0] sr_imask_i,
  output logic             acc_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [LVL_W-1:0] imask_o
);
  logic take;

  assign take = req_i && (lvl_i > sr_imask_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_o   <= 1'b0;
      vec_o   <= '0;
      imask_o <= '0;
    end else begin
      acc_o <= take;
      if (take) begin
        vec_o   <= irl_vector(lvl_i);
        imask_o <= lvl_i;
      end
    end
  end

  // R9
  acc_strict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_o |-> (imask_o > $past(sr_imask_i)));
  // R10
  vec_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_o |-> (vec_o == 8'd64 + {5'd0, imask_o[3:1]}));
  // R9
  no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> !acc_o);
endmodule

// File: rtl/irl_ctrl.sv
module irl_ctrl
  import irl_pkg::*;
#(
  parameter int NCPU = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rst_evt_i,
  input  logic                   vblank_i,
  input  logic                   hblank_i,
  input  logic                   pwm_i,
  input  logic [NCPU-1:0]        host_we_i,
  input  logic [NCPU-1:0]        host_d0_i,
  input  logic [NCPU-1:0]        cpu_we_i,
  input  logic [NCPU*ADDR_W-1:0] cpu_addr_i,
  input  logic [NCPU*4-1:0]      cpu_wdata_i,
  input  logic [NCPU-1:0]        acc_req_i,
  input  logic [NCPU*LVL_W-1:0]  sr_imask_i,
  output logic [NCPU*LVL_W-1:0]  irl_o,
  output logic [NCPU-1:0]        acc_o,
  output logic [NCPU*VEC_W-1:0]  vec_o,
  output logic [NCPU*LVL_W-1:0]  new_imask_o
);
  shared_t set_w;
  shared_t clr_w [NCPU];
  shared_t shared_q;
  dec_t    dec_w [NCPU];

  assign set_w = '{rs: rst_evt_i, vb: vblank_i, hb: hblank_i, pw: pwm_i};

  irl_shared_latch #(.NCPU(NCPU)) u_shared (
    .clk(clk), .rst_n(rst_n), .set_i(set_w), .clr_i(clr_w), .q_o(shared_q)
  );

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic [LVL_W-1:0] lvl_w;

    irl_regif u_dec (
      .we_i(cpu_we_i[c]), .addr_i(cpu_addr_i[c*ADDR_W +: ADDR_W]), .dec_o(dec_w[c])
    );

    assign clr_w[c] = '{rs: dec_w[c].rs, vb: dec_w[c].vb, hb: dec_w[c].hb, pw: dec_w[c].pw};

    irl_cpu_core u_core (
      .clk(clk), .rst_n(rst_n), .shared_i(shared_q), .dec_i(dec_w[c]),
      .mask_d_i(cpu_wdata_i[c*4 +: 4]), .host_we_i(host_we_i[c]),
      .host_d0_i(host_d0_i[c]), .lvl_o(lvl_w)
    );

    assign irl_o[c*LVL_W +: LVL_W] = lvl_w;

    irl_accept u_acc (
      .clk(clk), .rst_n(rst_n), .lvl_i(lvl_w), .req_i(acc_req_i[c]),
      .sr_imask_i(sr_imask_i[c*LVL_W +: LVL_W]), .acc_o(acc_o[c]),
      .vec_o(vec_o[c*VEC_W +: VEC_W]), .imask_o(new_imask_o[c*LVL_W +: LVL_W])
    );
  end
endmodule

// File: tb/sim_irl_ctrl.sv
module sim_irl_ctrl;
  logic clk = 0, rst_n = 0;
  logic rs = 0, vb = 0, hb = 0, pw = 0;
  logic [1:0] host_we = 0, host_d0 = 0, cpu_we = 0, req = 0;
  logic [15:0] addr = 0;
  logic [7:0] wdata = 0, srm = 0;
  logic [7:0] irl, nim;
  logic [1:0] acc;
  logic [15:0] vec;

  int errors = 0, checks = 0;
  // bench model
  logic [3:0] m_sh; // {rs,vb,hb,pw}
  logic [1:0] m_cmd;
  logic [3:0] m_mask [2];

  always #10 clk = ~clk;

  irl_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .rst_evt_i(rs), .vblank_i(vb), .hblank_i(hb), .pwm_i(pw),
    .host_we_i(host_we), .host_d0_i(host_d0), .cpu_we_i(cpu_we), .cpu_addr_i(addr),
    .cpu_wdata_i(wdata), .acc_req_i(req), .sr_imask_i(srm), .irl_o(irl), .acc_o(acc),
    .vec_o(vec), .new_imask_o(nim)
  );

  function automatic int exp_lvl(int c);
    if (m_sh[3]) return 14;
    if (m_sh[2] && m_mask[c][3]) return 12;
    if (m_sh[1] && m_mask[c][2]) return 10;
    if (m_cmd[c] && m_mask[c][1]) return 8;
    if (m_sh[0] && m_mask[c][0]) return 6;
    return 0;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    {rs, vb, hb, pw} = 0; host_we = 0; host_d0 = 0; cpu_we = 0; req = 0;
  endtask

  task automatic chk_levels(string tag);
    chk(tag, irl[3:0], exp_lvl(0));
    chk(tag, irl[7:4], exp_lvl(1));
  endtask

  // one-cycle stimulus already driven; release and sample after the level register
  task automatic finish_op(string tag);
    @(negedge clk); idle();
    @(negedge clk); chk_levels(tag);
  endtask

  function automatic void model_write(int c, logic [7:0] a, logic [3:0] d);
    case (a)
      8'h00: m_mask[c] = d;
      8'h14: m_sh[3] = 0;
      8'h16: m_sh[2] = 0;
      8'h18: m_sh[1] = 0;
      8'h1A: m_cmd[c] = 0;
      8'h1C: m_sh[0] = 0;
      default: ;
    endcase
  endfunction

  task automatic cpu_write(int c, logic [7:0] a, logic [3:0] d, string tag);
    @(negedge clk);
    cpu_we[c] = 1; addr[c*8 +: 8] = a; wdata[c*4 +: 4] = d;
    model_write(c, a, d);
    finish_op(tag);
  endtask

  task automatic pulse(logic [3:0] s, string tag);
    @(negedge clk);
    {rs, vb, hb, pw} = s;
    m_sh = m_sh | s;
    finish_op(tag);
  endtask

  task automatic host_set(int c, logic d0, string tag);
    @(negedge clk);
    host_we[c] = 1; host_d0[c] = d0;
    if (d0) m_cmd[c] = 1;
    finish_op(tag);
  endtask

  task automatic try_accept(int c, logic [3:0] sr, string tag);
    int l;
    l = exp_lvl(c);
    @(negedge clk);
    req[c] = 1; srm[c*4 +: 4] = sr;
    @(negedge clk); idle();
    chk(tag, acc[c], (l > sr) ? 1 : 0);
    if (l > sr) begin
      chk(tag, vec[c*8 +: 8], 64 + l / 2);
      chk(tag, nim[c*4 +: 4], l);
    end
    chk(tag, acc[1-c], 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] ofs [7];
    void'($urandom(32'd1234));
    ofs = '{8'h00, 8'h14, 8'h16, 8'h18, 8'h1A, 8'h1C, 8'h12};
    m_sh = 0; m_cmd = 0; m_mask[0] = 0; m_mask[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 irl", irl, 0);
    chk("R1 acc", acc, 0);

    // R3 reset source bypasses a zero mask; R5 seen by both
    pulse(4'b1000, "R3 R5 reset bypass");
    // R4 level lags latch by one clock
    @(negedge clk); {vb, hb, pw} = 3'b111; m_sh = m_sh | 4'b0111;
    cpu_write(0, 8'h00, 4'hF, "R3 mask cpu0");
    cpu_write(0, 8'h14, 0, "R7 R5 clear reset by cpu0");
    // R4 timing: mask write, sample after one clock is still old
    @(negedge clk); cpu_we[1] = 1; addr[15:8] = 8'h00; wdata[7:4] = 4'b0001;
    @(negedge clk); idle();
    chk("R4 not yet", irl[7:4], 0);
    m_mask[1] = 4'b0001;
    @(negedge clk); chk_levels("R4 one clock later");
    cpu_write(1, 8'h16, 0, "R5 R7 clear vb by cpu1");
    cpu_write(0, 8'h12, 0, "R7 ignored offset");
    cpu_write(1, 8'h18, 0, "R7 clear hb");
    // R6 command per cpu
    host_set(0, 0, "R6 bit0 zero ignored");
    host_set(0, 1, "R6 set cmd cpu0");
    host_set(1, 1, "R6 set cmd cpu1");
    cpu_write(1, 8'h00, 4'b0010, "R6 mask cmd cpu1");
    cpu_write(1, 8'h1A, 0, "R6 clear cmd cpu1 only");
    // R8 set and clear same cycle
    @(negedge clk);
    pw = 1; cpu_we[0] = 1; addr[7:0] = 8'h1C;
    finish_op("R8 set wins");
    // R9 equal level refused, R11 still pending and later accepted
    try_accept(0, 4'(exp_lvl(0)), "R9 equal refused");
    chk_levels("R11 pending after refuse");
    try_accept(0, 4'd0, "R10 R11 accept after sr lowered");
    chk_levels("R11 pending after accept");

    for (int i = 0; i < 400; i++) begin
      int k, c;
      k = $urandom_range(0, 5);
      c = $urandom_range(0, 1);
      case (k)
        0: pulse(4'($urandom_range(0, 15)), "R2 rand pulse");
        1: host_set(c, 1'($urandom_range(0, 1)), "R6 rand host");
        2, 3: cpu_write(c, ofs[$urandom_range(0, 6)], 4'($urandom_range(0, 15)), "R2 R7 rand write");
        default: try_accept(c, 4'($urandom_range(0, 15)), "R9 R10 rand accept");
      endcase
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule